// File: doc/BRIEF.md
# Script Instruction Fetch Sequencer

This block fetches variable-length script instructions for a DMA engine over a 32-bit bus master port. It reads the dwords of each instruction from memory and hands the complete instruction, with its dword count, to a decoder. The number of bus ownerships it uses depends on the opcode class and on whether burst opcode fetch is in effect. Burst opcode fetch is in effect only when it is enabled, prefetch is off and instructions do not come from on-chip script RAM.

For every ownership it requests, the block also selects the bus read command. The choice depends on whether the ownership fetches the opcode dword, on the read-line and read-multiple enables, and on cache mode. It also decides when fetching begins after software writes the instruction pointer. In automatic mode fetching begins at once. In manual mode it waits for an explicit start strobe. After each instruction is delivered, the block moves straight on to the next instruction address.

A bus ownership uses a simple handshake. The master holds `bus_req` together with a stable address, length and command. The slave asserts `bus_gnt`, then returns one dword per cycle, each marked by `bus_rvalid`, starting at `bus_addr`. When the master drops `bus_req`, the ownership ends.

Top module: `script_fetch_seq`

## Requirements
- R1: The opcode class is taken from bits [31:30] of the first dword. Class 2'b00 (plain) has 2 dwords, 2'b01 (indirect) has 3, 2'b10 (table indirect) has 4 and 2'b11 (memory-to-memory move) has 3.
- R2: When burst fetch is in effect, the first ownership of every instruction requests length 2 and covers dwords 0 and 1.
- R3: When burst fetch is in effect, any remaining dwords (1 or 2) are read in one later ownership, and `bus_req` is low for at least one cycle between the two ownerships.
- R4: When burst fetch is disabled, prefetch is on, or the script RAM source is selected, each dword is read in its own ownership of length 1.
- R5: An ownership that begins with dword 0 (the opcode fetch) uses 4'b1100 when read-multiple and cache mode are both on and its length is 2. Otherwise it uses 4'b0110.
- R6: Any other ownership uses 4'b1110 when read-line is on. Otherwise it follows the rule of R5.
- R7: With manual mode clear, a pointer write raises `bus_req` in the next cycle with `bus_addr` equal to the written pointer.
- R8: With manual mode set, a pointer write keeps `bus_req` low until a start strobe arrives. `bus_req` rises in the cycle after the strobe.
- R9: A start strobe has no effect when no pointer write is waiting for it. This holds both before any pointer write and while fetching.
- R10: `ins_valid` is a one-cycle pulse in the cycle after the last dword is captured. At that point `ins_len` holds the dword count and slot i of `ins_words` holds dword i.
- R11: If the grant is removed after part of a burst, the unread dwords are requested again, starting at the next unread address and with the remaining length.
- R12: The next instruction fetch begins at the previous instruction address plus 4 times its dword count.
- R13: While `bus_req` is held and no dword is transferred, `bus_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_en | input | 1 | Burst opcode fetch enable |
| cfg_prefetch_en | input | 1 | Prefetch on; turns off burst splitting |
| cfg_ram_src | input | 1 | Instructions come from on-chip script RAM; turns off burst splitting |
| cfg_read_line | input | 1 | Read-line command enable for non-opcode reads |
| cfg_read_mult | input | 1 | Read-multiple command enable |
| cfg_cache_on | input | 1 | Cache mode on |
| cfg_manual | input | 1 | Manual start mode |
| ptr_wr | input | 1 | Instruction pointer write strobe |
| ptr_data | input | ADDR_W | Written instruction pointer |
| start_pulse | input | 1 | Start strobe for manual mode |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_len | output | LEN_W | Dwords requested in this ownership |
| bus_cmd | output | 4 | Bus read command code |
| bus_addr | output | ADDR_W | Address of the next unread dword |
| bus_rvalid | input | 1 | Read data valid (only counts while granted) |
| bus_rdata | input | DATA_W | Read data |
| ins_valid | output | 1 | Instruction complete pulse |
| ins_len | output | CNT_W | Dword count of the delivered instruction |
| ins_words | output | MAX_DW*DATA_W | Captured dwords, dword i in slot i |

## Verification
The hardest case to reach is losing the grant after only part of a two-dword burst. In that state the request must be reissued with a new address, a shorter length and a non-opcode command, and all of this happens before the instruction is complete. The bus responder in the bench can be armed to drop its grant right after the first dword of the next ownership. The expected re-request of length 1 at the following address is queued ahead of time. The other stimulus runs short programs that mix all four opcode classes under each configuration that switches burst splitting on or off.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef enum logic [1:0] {
    CLS_PLAIN    = 2'b00,
    CLS_INDIRECT = 2'b01,
    CLS_TABLE    = 2'b10,
    CLS_MEMMOVE  = 2'b11
  } op_class_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_REQ,
    ST_GAP
  } seq_state_e;

  localparam logic [3:0] CMD_MEM_READ  = 4'b0110;
  localparam logic [3:0] CMD_READ_MULT = 4'b1100;
  localparam logic [3:0] CMD_READ_LINE = 4'b1110;

  // dword count of one instruction, by opcode class
  function automatic logic [2:0] class_dwords(input logic [1:0] cls);
    logic [2:0] n;
    case (op_class_e'(cls))
      CLS_PLAIN:    n = 3'd2;
      CLS_INDIRECT: n = 3'd3;
      CLS_TABLE:    n = 3'd4;
      default:      n = 3'd3;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sfs_split.sv
// Works out how many dwords the current ownership still has to read.
module sfs_split #(
  parameter int CNT_W    = 3,
  parameter int LEN_W    = 2,
  parameter int BURST_DW = 2
) (
  input  logic             burst_eff,
  input  logic [CNT_W-1:0] idx,
  input  logic [CNT_W-1:0] total,
  output logic [LEN_W-1:0] own_len
);
  localparam logic [CNT_W-1:0] BURST_N = CNT_W'(BURST_DW);

  logic [CNT_W-1:0] own_end;

  always_comb begin
    if (burst_eff) begin
      own_end = (idx < BURST_N) ? BURST_N : total;
    end else begin
      own_end = idx + 1'b1;
    end
    own_len = LEN_W'(own_end - idx);
  end
endmodule

// File: rtl/sfs_cmd.sv
// Bus read command for the current ownership.
module sfs_cmd #(
  parameter int LEN_W    = 2,
  parameter int BURST_DW = 2
) (
  input  logic             opcode_fetch,
  input  logic [LEN_W-1:0] own_len,
  input  logic             read_line,
  input  logic             read_mult,
  input  logic             cache_on,
  output logic [3:0]       cmd
);
  import sfs_pkg::*;

  logic mult_ok;

  always_comb begin
    mult_ok = read_mult & cache_on & (own_len == LEN_W'(BURST_DW));
    if (!opcode_fetch && read_line) begin
      cmd = CMD_READ_LINE;
    end else if (mult_ok) begin
      cmd = CMD_READ_MULT;
    end else begin
      cmd = CMD_MEM_READ;
    end
  end
endmodule

// File: rtl/sfs_capture.sv
// Holding slots for the dwords of one instruction.
module sfs_capture #(
  parameter int DATA_W = 32,
  parameter int SLOTS  = 4,
  parameter int IDX_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [SLOTS*DATA_W-1:0]   words
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              slot_en;

    assign slot_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= wr_data;
      end
    end

    assign words[g*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/script_fetch_seq.sv
module script_fetch_seq #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int MAX_DW   = 4,
  parameter int CNT_W    = 3,
  parameter int LEN_W    = 2,
  parameter int BURST_DW = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_burst_en,
  input  logic                     cfg_prefetch_en,
  input  logic                     cfg_ram_src,
  input  logic                     cfg_read_line,
  input  logic                     cfg_read_mult,
  input  logic                     cfg_cache_on,
  input  logic                     cfg_manual,
  input  logic                     ptr_wr,
  input  logic [ADDR_W-1:0]        ptr_data,
  input  logic                     start_pulse,
  output logic                     bus_req,
  input  logic                     bus_gnt,
  output logic [LEN_W-1:0]         bus_len,
  output logic [3:0]               bus_cmd,
  output logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_rvalid,
  input  logic [DATA_W-1:0]        bus_rdata,
  output logic                     ins_valid,
  output logic [CNT_W-1:0]         ins_len,
  output logic [MAX_DW*DATA_W-1:0] ins_words
);
  import sfs_pkg::*;

  localparam logic [CNT_W-1:0] FIRST_TOTAL = CNT_W'(BURST_DW);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  tot_q, tot_d;
  logic [CNT_W-1:0]  len_q, len_d;
  logic              vld_q, vld_d;

  logic              burst_eff;
  logic              beat;
  logic              last_dw;
  logic              own_done;
  logic [CNT_W-1:0]  tot_now;
  logic [LEN_W-1:0]  own_len;

  assign burst_eff = cfg_burst_en & ~cfg_prefetch_en & ~cfg_ram_src;

  sfs_split #(.CNT_W(CNT_W), .LEN_W(LEN_W), .BURST_DW(BURST_DW)) u_split (
    .burst_eff (burst_eff),
    .idx       (idx_q),
    .total     (tot_q),
    .own_len   (own_len)
  );

  sfs_cmd #(.LEN_W(LEN_W), .BURST_DW(BURST_DW)) u_cmd (
    .opcode_fetch (idx_q == '0),
    .own_len      (own_len),
    .read_line    (cfg_read_line),
    .read_mult    (cfg_read_mult),
    .cache_on     (cfg_cache_on),
    .cmd          (bus_cmd)
  );

  sfs_capture #(.DATA_W(DATA_W), .SLOTS(MAX_DW), .IDX_W(CNT_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (beat),
    .wr_idx  (idx_q),
    .wr_data (bus_rdata),
    .words   (ins_words)
  );

  // class is decoded the moment dword 0 arrives
  assign tot_now  = (idx_q == '0) ? CNT_W'(class_dwords(bus_rdata[DATA_W-1 -: 2])) : tot_q;
  assign beat     = (state_q == ST_REQ) && bus_gnt && bus_rvalid;
  assign last_dw  = beat && ((idx_q + 1'b1) == tot_now);
  assign own_done = beat && (own_len == LEN_W'(1));

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    idx_d   = idx_q;
    tot_d   = tot_q;
    len_d   = len_q;
    vld_d   = 1'b0;
    if (ptr_wr) begin
      pc_d    = ptr_data;
      idx_d   = '0;
      tot_d   = FIRST_TOTAL;
      state_d = cfg_manual ? ST_ARMED : ST_REQ;
    end else begin
      case (state_q)
        ST_ARMED: if (start_pulse) state_d = ST_REQ;
        ST_REQ: begin
          if (beat) begin
            idx_d = idx_q + 1'b1;
            tot_d = tot_now;
            if (last_dw) begin
              pc_d    = pc_q + ADDR_W'({tot_now, 2'b00});
              idx_d   = '0;
              tot_d   = FIRST_TOTAL;
              len_d   = tot_now;
              vld_d   = 1'b1;
              state_d = ST_GAP;
            end else if (own_done) begin
              state_d = ST_GAP;
            end
          end
        end
        ST_GAP:  state_d = ST_REQ;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      idx_q   <= '0;
      tot_q   <= FIRST_TOTAL;
      len_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      idx_q   <= idx_d;
      tot_q   <= tot_d;
      len_q   <= len_d;
      vld_q   <= vld_d;
    end
  end

  assign bus_req   = (state_q == ST_REQ);
  assign bus_len   = own_len;
  assign bus_addr  = pc_q + ADDR_W'({idx_q, 2'b00});
  assign ins_valid = vld_q;
  assign ins_len   = len_q;

  // ---------------- assertions ----------------
  p_auto_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr && !cfg_manual |=> bus_req && (bus_addr == $past(ptr_data)));

  p_manual_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr && cfg_manual |=> !bus_req);

  p_first_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && burst_eff && (idx_q == '0) |-> bus_len == LEN_W'(BURST_DW));

  p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !burst_eff |-> bus_len == LEN_W'(1));

  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat && (bus_len == LEN_W'(1)) && !ptr_wr |=> !bus_req);

  p_line_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && cfg_read_line && (idx_q != '0) |-> bus_cmd == CMD_READ_LINE);

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> !ins_valid);

  p_addr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !(bus_gnt && bus_rvalid) && !ptr_wr |=> bus_req && $stable(bus_addr));

endmodule

// File: tb/script_fetch_seq_test.sv
`timescale 1ns/1ps
module script_fetch_seq_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         c_burst, c_pref, c_ram, c_rl, c_rm, c_cache, c_manual;
  logic         ptr_wr, start_pulse;
  logic [31:0]  ptr_data;
  logic         bus_req, gnt, rvalid;
  logic [1:0]   bus_len;
  logic [3:0]   bus_cmd;
  logic [31:0]  bus_addr, rdata;
  logic         ins_valid;
  logic [2:0]   ins_len;
  logic [127:0] ins_words;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [31:0]  mem [256];
  logic [37:0]  q_own[$];
  string        q_otag[$];
  int           q_ilen[$];
  logic [127:0] q_iw[$];
  logic [31:0]  wp;
  bit           hold;
  bit           drop_arm;
  bit           own_drop;
  int           beats;
  int           tagc;

  always #2.5 clk = ~clk;

  script_fetch_seq uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_burst_en(c_burst), .cfg_prefetch_en(c_pref), .cfg_ram_src(c_ram),
    .cfg_read_line(c_rl), .cfg_read_mult(c_rm), .cfg_cache_on(c_cache),
    .cfg_manual(c_manual), .ptr_wr(ptr_wr), .ptr_data(ptr_data),
    .start_pulse(start_pulse), .bus_req(bus_req), .bus_gnt(gnt),
    .bus_len(bus_len), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_rvalid(rvalid), .bus_rdata(rdata), .ins_valid(ins_valid),
    .ins_len(ins_len), .ins_words(ins_words)
  );

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] op_cmd(input int len);
    return (c_rm && c_cache && len == 2) ? 4'b1100 : 4'b0110;   // R5
  endfunction

  function automatic logic [3:0] nonop_cmd(input int len);
    return c_rl ? 4'b1110 : op_cmd(len);                        // R6
  endfunction

  task automatic push_own(input logic [31:0] a, input int len, input logic [3:0] cmd,
                          input string tag);
    q_own.push_back({a, 2'(len), cmd});
    q_otag.push_back(tag);
  endtask

  // appends one instruction at wp and queues what the bus and decoder must see
  task automatic add_ins(input logic [1:0] cls, input bit drop);
    int n;
    logic [127:0] w;
    logic [31:0]  a;
    bit           be;
    n  = (cls == 2'b00) ? 2 : (cls == 2'b10) ? 4 : 3;  // R1
    a  = wp;
    w  = '0;
    be = c_burst && !c_pref && !c_ram;
    tagc++;
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = (i == 0) ? {cls, 22'h0, 8'(tagc)} : (32'h3C00_0000 ^ (32'(tagc) << 8) ^ 32'(i));
      mem[8'((a >> 2) + 32'(i))] = d;
      w[i*32 +: 32] = d;
    end
    q_ilen.push_back(n);
    q_iw.push_back(w);
    if (be) begin
      if (drop) begin
        push_own(a, 2, op_cmd(2), "R2 R5");
        push_own(a + 4, 1, nonop_cmd(1), "R11 R6");
      end else begin
        push_own(a, 2, op_cmd(2), "R2 R5");
      end
      if (n > 2) push_own(a + 8, n - 2, nonop_cmd(n - 2), "R3 R6");
    end else begin
      for (int i = 0; i < n; i++)
        push_own(a + 32'(4 * i), 1, (i == 0) ? op_cmd(1) : nonop_cmd(1), "R4 R5 R6");
    end
    wp = wp + 32'(4 * n);
  endtask

  task automatic set_cfg(input bit b, input bit p, input bit r, input bit rl,
                         input bit rm, input bit ca, input bit man);
    @(negedge clk);
    hold = 1;
    c_burst = b; c_pref = p; c_ram = r; c_rl = rl; c_rm = rm; c_cache = ca; c_manual = man;
  endtask

  task automatic write_ptr(input logic [31:0] a);
    @(negedge clk);
    ptr_wr = 1; ptr_data = a;
    @(negedge clk);
    ptr_wr = 0;
    if (!c_manual)
      check(bus_req && bus_addr == a, "R7 auto start", {bus_req, bus_addr}, {1'b1, a});
    hold = 0;
  endtask

  task automatic wait_done();
    int cnt = 0;
    while ((q_own.size() != 0 || q_ilen.size() != 0) && cnt < 3000) begin
      @(negedge clk);
      cnt++;
    end
    check(q_own.size() == 0 && q_ilen.size() == 0, "R10 program completes",
          128'(q_ilen.size()), 128'd0);
    repeat (3) @(negedge clk);
    // R12 next fetch address, R13 held request
    check(bus_req && bus_addr == wp, "R12 next address", {bus_req, bus_addr}, {1'b1, wp});
  endtask

  // responder and ownership monitor
  always @(negedge clk) begin
    if (!rst_n || hold || !bus_req) begin
      gnt = 0; rvalid = 0;
    end else if (!gnt) begin
      if (q_own.size() != 0) begin
        logic [37:0] e;
        string t;
        e = q_own.pop_front();
        t = q_otag.pop_front();
        check({bus_addr, bus_len, bus_cmd} == e, t, {bus_addr, bus_len, bus_cmd}, e);
        gnt = 1; rvalid = 0; beats = 0;
        own_drop = drop_arm; drop_arm = 0;
      end
    end else begin
      if (own_drop && beats == 1) begin
        gnt = 0; rvalid = 0; own_drop = 0;
      end else begin
        rvalid = 1;
        rdata  = mem[bus_addr[9:2]];
        beats++;
      end
    end
  end

  // instruction scoreboard
  always @(negedge clk) begin
    if (rst_n && ins_valid) begin
      if (q_ilen.size() == 0) begin
        check(0, "R10 unexpected instruction", 128'(ins_len), 128'd0);
      end else begin
        int n;
        logic [127:0] w, m;
        n = q_ilen.pop_front();
        w = q_iw.pop_front();
        m = '0;
        for (int i = 0; i < n; i++) m[i*32 +: 32] = '1;
        check(int'(ins_len) == n, "R1 R10 length", 128'(ins_len), 128'(n));
        check((ins_words & m) == w, "R10 words", ins_words & m, w);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst_n = 0; hold = 1; drop_arm = 0; own_drop = 0; tagc = 0;
    gnt = 0; rvalid = 0; rdata = '0;
    ptr_wr = 0; ptr_data = '0; start_pulse = 0;
    c_burst = 0; c_pref = 0; c_ram = 0; c_rl = 0; c_rm = 0; c_cache = 0; c_manual = 0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!bus_req && !ins_valid, "reset state", {bus_req, ins_valid}, 2'b00);
    rst_n = 1;
    @(negedge clk);
    // R9: start with nothing armed
    start_pulse = 1;
    @(negedge clk);
    start_pulse = 0;
    repeat (3) @(negedge clk);
    check(!bus_req, "R9 start ignored when idle", 128'(bus_req), 128'd0);

    // burst, all classes, plain commands
    set_cfg(1, 0, 0, 0, 0, 0, 0);
    wp = 32'h40;
    add_ins(2'b00, 0); add_ins(2'b01, 0); add_ins(2'b10, 0); add_ins(2'b11, 0);
    write_ptr(32'h40);
    wait_done();

    // R13 while waiting without grant; R9 start during fetching
    held = bus_addr;
    start_pulse = 1;
    @(negedge clk);
    start_pulse = 0;
    repeat (3) @(negedge clk);
    check(bus_req && bus_addr == held, "R13 R9 held request", {bus_req, bus_addr}, {1'b1, held});

    // burst with read-line and read-multiple
    set_cfg(1, 0, 0, 1, 1, 1, 0);
    wp = 32'h100;
    add_ins(2'b10, 0); add_ins(2'b11, 0); add_ins(2'b00, 0);
    write_ptr(32'h100);
    wait_done();

    // burst with read-multiple only
    set_cfg(1, 0, 0, 0, 1, 1, 0);
    wp = 32'h180;
    add_ins(2'b10, 0); add_ins(2'b01, 0);
    write_ptr(32'h180);
    wait_done();

    // read-multiple without cache mode
    set_cfg(1, 0, 0, 0, 1, 0, 0);
    wp = 32'h200;
    add_ins(2'b10, 0);
    write_ptr(32'h200);
    wait_done();

    // R4: prefetch overrides burst
    set_cfg(1, 1, 0, 1, 1, 1, 0);
    wp = 32'h240;
    add_ins(2'b01, 0); add_ins(2'b10, 0);
    write_ptr(32'h240);
    wait_done();

    // R4: script RAM source overrides burst
    set_cfg(1, 0, 1, 0, 0, 0, 0);
    wp = 32'h280;
    add_ins(2'b11, 0);
    write_ptr(32'h280);
    wait_done();

    // R4: burst disabled
    set_cfg(0, 0, 0, 1, 0, 0, 0);
    wp = 32'h2C0;
    add_ins(2'b00, 0); add_ins(2'b10, 0);
    write_ptr(32'h2C0);
    wait_done();

    // R8: manual start
    set_cfg(1, 0, 0, 0, 0, 0, 1);
    wp = 32'h300;
    add_ins(2'b01, 0);
    write_ptr(32'h300);
    repeat (5) @(negedge clk);
    check(!bus_req, "R8 manual waits", 128'(bus_req), 128'd0);
    start_pulse = 1;
    @(negedge clk);
    start_pulse = 0;
    check(bus_req && bus_addr == 32'h300, "R8 start begins fetch",
          {bus_req, bus_addr}, {1'b1, 32'h300});
    wait_done();

    // R11: grant lost after first dword of a burst
    set_cfg(1, 0, 0, 1, 0, 0, 0);
    wp = 32'h340;
    drop_arm = 1;
    add_ins(2'b11, 1);
    add_ins(2'b00, 0);
    write_ptr(32'h340);
    wait_done();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule